// File: doc/BRIEF.md
# Single-Issue Processor Memory-Access Sequencer

This block is the control engine of a non-pipelined processor core. It steps each instruction through three phases: a fetch on the instruction port, an optional load or store on the data port, and completion. Completion advances the program counter and starts the next fetch. Decoding, execution, address translation and the caches are outside the block. It only sequences requests and responses.

Both memory ports use the same handshake. The block raises a request-valid for one cycle, and the port answers in that same cycle with an accept. If the port refuses the request, the block keeps it and waits. The port later sends a retry pulse, and the block then presents the kept request a second time, which the port must take. A separate response strobe ends the transaction.

An activate command starts the engine after a programmable number of cycles. A switch-out command parks a running engine, and every switch-out is acknowledged. Illegal handshake events set a sticky error flag and do not change the state.

Top module: `uproc_mem_seq`

## Requirements
- R1: After a synchronous active-low reset, `seq_state` is Idle (code 0) and `pc` equals RESET_PC. The pulse outputs, both request valids, both uncached counters and `proto_err` are all zero.
- R2: When `act_req` is sampled in Idle at edge k with `act_delay` = D, `seq_state` becomes Running (code 1). `irq_chk` is high for exactly the single cycle that follows edge k+D+1.
- R3: The cycle after an `irq_chk` pulse, `if_req_valid` is high for one cycle. In that cycle `if_req_addr` equals `pc` and `if_req_size` equals INSN_BYTES.
- R4: If `if_req_accept` is high in the request cycle, the state becomes IfetchWait (code 3). If it is low, the state becomes IfetchRetry (code 2) and stays there until a retry pulse arrives.
- R5: A retry pulse on `if_retry` while in IfetchRetry moves the state to IfetchWait. In the next cycle the same address is presented again on `if_req_valid`, and the port must take it without regard to accept.
- R6: An instruction response with `ins_is_mem` low returns the state to Running. In the next cycle `pc_adv` is high, `pc` has grown by PC_STEP, and `irq_chk` is high to start the next fetch.
- R7: An instruction response with `ins_is_mem` high captures the load/store descriptor. The next cycle presents `d_req_valid` with `d_req_we` (1 = store), `d_req_addr` and `d_req_size` (0,1,2,3 = 1,2,4,8 bytes). Accept leads to DataWait (code 5). Refusal leads to DataRetry (code 4), from which a `d_retry` pulse leads to DataWait with one replayed request.
- R8: A `d_resp` pulse with `d_resp_ok` high in DataWait returns the state to Running and completes the instruction exactly as in R6. A `d_resp` pulse with `d_resp_ok` low sets `proto_err` and leaves the state in DataWait.
- R9: An instruction response that carries a memory descriptor marked uncacheable increments `unc_rd_cnt` (load) or `unc_wr_cnt` (store) by one, visible in the next cycle. A cacheable access changes neither counter.
- R10: A `swout_req` pulse makes `swout_ack` high in the next cycle, whatever the state. From Running, the state becomes SwitchedOut (code 6) and any pending fetch is dropped. In every other state the state is unchanged.
- R11: `proto_err` is set and stays set until reset, with the state unchanged, on any of these events: a retry pulse when no request is held, a response outside the matching wait state, or `act_req` outside Idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| act_req | input | 1 | Activate command pulse |
| act_delay | input | DLY_W | Cycles to wait before the first fetch |
| swout_req | input | 1 | Switch-out command pulse |
| swout_ack | output | 1 | Switch-out acknowledge pulse |
| irq_chk | output | 1 | Interrupt-check pulse at the start of each fetch |
| pc_adv | output | 1 | Instruction-completion pulse |
| pc | output | AW | Program counter |
| seq_state | output | 3 | Current sequencer state code |
| proto_err | output | 1 | Sticky protocol-error flag |
| if_req_valid | output | 1 | Instruction-port request valid |
| if_req_addr | output | AW | Instruction fetch address |
| if_req_size | output | SZ_W | Fetch size in bytes |
| if_req_accept | input | 1 | Instruction port takes the request |
| if_retry | input | 1 | Instruction port retry pulse |
| if_resp | input | 1 | Instruction response strobe |
| ins_is_mem | input | 1 | Fetched instruction is a load or store (valid with if_resp) |
| ls_we | input | 1 | Descriptor: 1 = store, 0 = load |
| ls_addr | input | AW | Descriptor: data address |
| ls_size | input | 2 | Descriptor: size code |
| ls_uncached | input | 1 | Descriptor: uncacheable access |
| d_req_valid | output | 1 | Data-port request valid |
| d_req_we | output | 1 | Data request is a write |
| d_req_addr | output | AW | Data request address |
| d_req_size | output | 2 | Data request size code |
| d_req_accept | input | 1 | Data port takes the request |
| d_retry | input | 1 | Data port retry pulse |
| d_resp | input | 1 | Data response strobe |
| d_resp_ok | input | 1 | Data response reports success |
| unc_rd_cnt | output | CNT_W | Uncached load events |
| unc_wr_cnt | output | CNT_W | Uncached store events |

## Verification
The bench builds the block with DLY_W = 4 and RESET_PC = 0x200, and leaves the other parameters at their defaults. The narrow delay field makes the first-fetch delay short enough to count cycle by cycle, from zero up to a mid-range value, so the bench checks the exact cycle of the interrupt-check pulse. The non-zero reset PC makes a correct reset visible, and each fetch address after it depends on the PC_STEP increments. The default 16-bit counters leave the uncached event counts well away from wrap.

// File: rtl/uproc_seq_pkg.sv
`timescale 1ns/1ps
// Shared types for the memory-access sequencer.
// Assumes: state codes are visible at the top port and must stay fixed.
package uproc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RUN    = 3'd1,
        ST_IRETRY = 3'd2,
        ST_IWAIT  = 3'd3,
        ST_DRETRY = 3'd4,
        ST_DWAIT  = 3'd5,
        ST_SWOUT  = 3'd6
    } seq_st_e;

    // Data access size code: 0,1,2,3 -> 1,2,4,8 bytes
    typedef logic [1:0] acc_size_t;

endpackage

// File: rtl/uproc_seq_timer.sv
`timescale 1ns/1ps
// Start-delay timer: after a load, fires once when the loaded count has run out.
// Assumes: load and cancel are never high together; fire is combinational.
module uproc_seq_timer #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] dly,
    input  logic             cancel,
    output logic             fire
);

    logic             armed;
    logic [DLY_W-1:0] cnt;

    assign fire = armed && (cnt == '0);

    // Count the remaining delay down and disarm after firing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (load) begin
            armed <= 1'b1;
            cnt   <= dly;
        end else if (cancel || fire) begin
            armed <= 1'b0;
        end else if (armed) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/uproc_seq_evcnt.sv
`timescale 1ns/1ps
// Event counter: adds one per cycle in which inc is high.
// Assumes: width is large enough that wrap is acceptable.
module uproc_seq_evcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);

    // Accumulate events
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + 1'b1;
    end

endmodule

// File: rtl/uproc_mem_seq.sv
`timescale 1ns/1ps
// Memory-access sequencer of a single-issue, non-pipelined core.
// Steps each instruction through fetch, optional data access and completion,
// with accept/retry/response handshakes on an instruction and a data port.
// Assumes: a port samples accept in the cycle request-valid is high; a request
// presented in a wait state is a replay that the port must take.
module uproc_mem_seq
    import uproc_seq_pkg::*;
#(
    parameter int          AW         = 32,
    parameter int          DLY_W      = 8,
    parameter int          CNT_W      = 16,
    parameter int          INSN_BYTES = 4,
    parameter int          PC_STEP    = 4,
    parameter logic [31:0] RESET_PC   = 32'h0000_1000,
    localparam int         SZ_W       = $clog2(INSN_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_req,
    input  logic [DLY_W-1:0] act_delay,
    input  logic             swout_req,
    output logic             swout_ack,
    output logic             irq_chk,
    output logic             pc_adv,
    output logic [AW-1:0]    pc,
    output logic [2:0]       seq_state,
    output logic             proto_err,
    output logic             if_req_valid,
    output logic [AW-1:0]    if_req_addr,
    output logic [SZ_W-1:0]  if_req_size,
    input  logic             if_req_accept,
    input  logic             if_retry,
    input  logic             if_resp,
    input  logic             ins_is_mem,
    input  logic             ls_we,
    input  logic [AW-1:0]    ls_addr,
    input  logic [1:0]       ls_size,
    input  logic             ls_uncached,
    output logic             d_req_valid,
    output logic             d_req_we,
    output logic [AW-1:0]    d_req_addr,
    output logic [1:0]       d_req_size,
    input  logic             d_req_accept,
    input  logic             d_retry,
    input  logic             d_resp,
    input  logic             d_resp_ok,
    output logic [CNT_W-1:0] unc_rd_cnt,
    output logic [CNT_W-1:0] unc_wr_cnt
);

    localparam logic [AW-1:0] PC_INIT = AW'(RESET_PC);
    localparam logic [AW-1:0] PC_INC  = AW'(PC_STEP);

    seq_st_e    st;
    logic       held_i, held_d;
    logic       if_vld, d_vld, irq_q, adv_q, ack_q, err_q;
    logic       d_we_q;
    logic [AW-1:0] d_addr_q, pc_q;
    acc_size_t  d_size_q;
    logic       tmr_fire, tmr_load, tmr_cancel;
    logic       swout_run, mem_capture, err_ev;

    assign tmr_load    = act_req && (st == ST_IDLE);
    assign swout_run   = swout_req && (st == ST_RUN);
    assign tmr_cancel  = swout_run;
    assign mem_capture = if_resp && (st == ST_IWAIT) && ins_is_mem;

    // Classify events that break the handshake rules
    always_comb begin
        err_ev = 1'b0;
        if (if_retry && !(st == ST_IRETRY && held_i)) err_ev = 1'b1;
        if (d_retry  && !(st == ST_DRETRY && held_d)) err_ev = 1'b1;
        if (if_resp  && (st != ST_IWAIT))             err_ev = 1'b1;
        if (d_resp   && ((st != ST_DWAIT) || !d_resp_ok)) err_ev = 1'b1;
        if (act_req  && (st != ST_IDLE))              err_ev = 1'b1;
    end

    uproc_seq_timer #(.DLY_W(DLY_W)) start_tmr_i (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .dly(act_delay),
        .cancel(tmr_cancel), .fire(tmr_fire)
    );

    uproc_seq_evcnt #(.W(CNT_W)) unc_rd_i (
        .clk(clk), .rst_n(rst_n), .inc(mem_capture && ls_uncached && !ls_we),
        .count(unc_rd_cnt)
    );

    uproc_seq_evcnt #(.W(CNT_W)) unc_wr_i (
        .clk(clk), .rst_n(rst_n), .inc(mem_capture && ls_uncached && ls_we),
        .count(unc_wr_cnt)
    );

    // Main sequencing: state, held requests, pulses, PC and descriptor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            held_i   <= 1'b0;
            held_d   <= 1'b0;
            if_vld   <= 1'b0;
            d_vld    <= 1'b0;
            irq_q    <= 1'b0;
            adv_q    <= 1'b0;
            ack_q    <= 1'b0;
            err_q    <= 1'b0;
            pc_q     <= PC_INIT;
            d_we_q   <= 1'b0;
            d_addr_q <= '0;
            d_size_q <= '0;
        end else begin
            irq_q  <= 1'b0;
            adv_q  <= 1'b0;
            if_vld <= 1'b0;
            d_vld  <= 1'b0;
            ack_q  <= swout_req;
            err_q  <= err_q || err_ev;
            if (st == ST_RUN && tmr_fire) irq_q  <= 1'b1;
            if (st == ST_RUN && irq_q)    if_vld <= 1'b1;
            unique case (st)
                ST_IDLE: begin
                    if (act_req) st <= ST_RUN;
                end
                ST_RUN: begin
                    if (if_vld) begin
                        st     <= if_req_accept ? ST_IWAIT : ST_IRETRY;
                        held_i <= !if_req_accept;
                    end else if (d_vld) begin
                        st     <= d_req_accept ? ST_DWAIT : ST_DRETRY;
                        held_d <= !d_req_accept;
                    end
                end
                ST_IRETRY: begin
                    if (if_retry && held_i) begin
                        st     <= ST_IWAIT;
                        held_i <= 1'b0;
                        if_vld <= 1'b1;
                    end
                end
                ST_IWAIT: begin
                    if (if_resp) begin
                        st <= ST_RUN;
                        if (ins_is_mem) begin
                            d_vld    <= 1'b1;
                            d_we_q   <= ls_we;
                            d_addr_q <= ls_addr;
                            d_size_q <= ls_size;
                        end else begin
                            pc_q  <= pc_q + PC_INC;
                            adv_q <= 1'b1;
                            irq_q <= 1'b1;
                        end
                    end
                end
                ST_DRETRY: begin
                    if (d_retry && held_d) begin
                        st     <= ST_DWAIT;
                        held_d <= 1'b0;
                        d_vld  <= 1'b1;
                    end
                end
                ST_DWAIT: begin
                    if (d_resp && d_resp_ok) begin
                        st    <= ST_RUN;
                        pc_q  <= pc_q + PC_INC;
                        adv_q <= 1'b1;
                        irq_q <= 1'b1;
                    end
                end
                default: ;
            endcase
            if (swout_run) begin
                st     <= ST_SWOUT;
                irq_q  <= 1'b0;
                if_vld <= 1'b0;
                d_vld  <= 1'b0;
            end
        end
    end

    assign seq_state    = st;
    assign proto_err    = err_q;
    assign swout_ack    = ack_q;
    assign irq_chk      = irq_q;
    assign pc_adv       = adv_q;
    assign pc           = pc_q;
    assign if_req_valid = if_vld;
    assign if_req_addr  = pc_q;
    assign if_req_size  = SZ_W'(INSN_BYTES);
    assign d_req_valid  = d_vld;
    assign d_req_we     = d_we_q;
    assign d_req_addr   = d_addr_q;
    assign d_req_size   = d_size_q;

    // R1: only the seven defined state codes occur
    p_state_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        seq_state != 3'd7);

    // R3: an interrupt check is followed by a fetch request
    p_fetch_after_check_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_chk && !swout_req) |=> if_req_valid);

    // R5: a retry in IfetchRetry lands in IfetchWait with a replay
    p_retry_replays_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 3'd2 && if_retry) |=> (seq_state == 3'd3 && if_req_valid));

    // R6: the PC changes only together with the completion pulse
    p_pc_moves_on_adv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pc) |-> pc_adv);

    // R7: never requests on both ports at once
    p_one_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({if_req_valid, d_req_valid}));

    // R10: acknowledge only follows a switch-out command
    p_ack_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        swout_ack |-> $past(swout_req));

    // R11: the error flag never clears on its own
    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

endmodule

// File: tb/uproc_mem_seq_tb_top.sv
`timescale 1ns/1ps
// Directed bench for the memory-access sequencer; one task per scenario.
module uproc_mem_seq_tb_top;

    localparam int          AW    = 32;
    localparam int          DLY_W = 4;
    localparam int          CNT_W = 16;
    localparam logic [31:0] RPC   = 32'h0000_0200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic act_req = 0, swout_req = 0;
    logic [DLY_W-1:0] act_delay = '0;
    logic if_req_accept = 0, if_retry = 0, if_resp = 0, ins_is_mem = 0;
    logic ls_we = 0, ls_uncached = 0;
    logic [AW-1:0] ls_addr = '0;
    logic [1:0] ls_size = '0;
    logic d_req_accept = 0, d_retry = 0, d_resp = 0, d_resp_ok = 0;
    logic swout_ack, irq_chk, pc_adv, proto_err, if_req_valid, d_req_valid, d_req_we;
    logic [AW-1:0] pc, if_req_addr, d_req_addr;
    logic [2:0] seq_state, if_req_size;
    logic [1:0] d_req_size;
    logic [CNT_W-1:0] unc_rd_cnt, unc_wr_cnt;

    int n_chk = 0;
    int n_err = 0;
    logic [AW-1:0] pc_exp;
    int exp_rd = 0;
    int exp_wr = 0;

    always #2 clk = ~clk;

    uproc_mem_seq #(.AW(AW), .DLY_W(DLY_W), .CNT_W(CNT_W), .RESET_PC(RPC)) dut_i (
        .clk(clk), .rst_n(rst_n), .act_req(act_req), .act_delay(act_delay),
        .swout_req(swout_req), .swout_ack(swout_ack), .irq_chk(irq_chk),
        .pc_adv(pc_adv), .pc(pc), .seq_state(seq_state), .proto_err(proto_err),
        .if_req_valid(if_req_valid), .if_req_addr(if_req_addr), .if_req_size(if_req_size),
        .if_req_accept(if_req_accept), .if_retry(if_retry), .if_resp(if_resp),
        .ins_is_mem(ins_is_mem), .ls_we(ls_we), .ls_addr(ls_addr), .ls_size(ls_size),
        .ls_uncached(ls_uncached), .d_req_valid(d_req_valid), .d_req_we(d_req_we),
        .d_req_addr(d_req_addr), .d_req_size(d_req_size), .d_req_accept(d_req_accept),
        .d_retry(d_retry), .d_resp(d_resp), .d_resp_ok(d_resp_ok),
        .unc_rd_cnt(unc_rd_cnt), .unc_wr_cnt(unc_wr_cnt)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        pc_exp = RPC;
        exp_rd = 0;
        exp_wr = 0;
    endtask

    // R1: reset values
    task automatic test_reset();
        do_reset();
        chk("R1 state", seq_state, 0);
        chk("R1 pc", pc, RPC);
        chk("R1 pulses", {irq_chk, pc_adv, swout_ack, if_req_valid, d_req_valid}, 0);
        chk("R1 err", proto_err, 0);
        chk("R1 counters", {unc_rd_cnt, unc_wr_cnt}, 0);
    endtask

    // R2 + R3: activation delay and first fetch request
    task automatic test_activate(input int d);
        act_req = 1; act_delay = DLY_W'(d);
        tick();
        act_req = 0;
        chk("R2 running", seq_state, 1);
        for (int i = 1; i <= d + 1; i++) begin
            tick();
            chk("R2 irq timing", irq_chk, (i == d + 1));
        end
        tick();
        chk("R3 valid", if_req_valid, 1);
        chk("R3 addr", if_req_addr, pc_exp);
        chk("R3 size", if_req_size, 4);
        chk("R3 irq done", irq_chk, 0);
    endtask

    // R4 + R6: accepted fetch of a non-memory instruction
    task automatic test_fetch_plain();
        if_req_accept = 1;
        tick();
        if_req_accept = 0;
        chk("R4 wait", seq_state, 3);
        chk("R4 valid drop", if_req_valid, 0);
        if_resp = 1; ins_is_mem = 0;
        tick();
        if_resp = 0;
        pc_exp = pc_exp + 4;
        chk("R6 running", seq_state, 1);
        chk("R6 adv", pc_adv, 1);
        chk("R6 pc", pc, pc_exp);
        chk("R6 irq", irq_chk, 1);
        tick();
        chk("R6 next fetch", if_req_valid, 1);
        chk("R6 next addr", if_req_addr, pc_exp);
        chk("R6 adv pulse", pc_adv, 0);
    endtask

    // R4 + R5: refused fetch, replayed on retry
    task automatic test_fetch_refuse();
        if_req_accept = 0;
        tick();
        chk("R4 retry state", seq_state, 2);
        chk("R4 no valid", if_req_valid, 0);
        tick();
        chk("R4 retry holds", seq_state, 2);
        if_retry = 1;
        tick();
        if_retry = 0;
        chk("R5 wait", seq_state, 3);
        chk("R5 replay", if_req_valid, 1);
        chk("R5 replay addr", if_req_addr, pc_exp);
        tick();
        chk("R5 replay once", if_req_valid, 0);
        chk("R5 still wait", seq_state, 3);
    endtask

    // R10: switch-out outside Running leaves the state alone
    task automatic test_swout_busy();
        swout_req = 1;
        tick();
        swout_req = 0;
        chk("R10 ack busy", swout_ack, 1);
        chk("R10 state kept", seq_state, 3);
        tick();
        chk("R10 ack pulse", swout_ack, 0);
    endtask

    // R7 + R8 + R9: memory instruction from IfetchWait back to IfetchWait
    task automatic test_data(input logic we, input logic unc, input logic [AW-1:0] a,
                             input logic [1:0] sz, input logic refuse);
        ins_is_mem = 1; ls_we = we; ls_uncached = unc; ls_addr = a; ls_size = sz;
        if_resp = 1;
        tick();
        if_resp = 0; ins_is_mem = 0;
        if (unc && !we) exp_rd++;
        if (unc && we) exp_wr++;
        chk("R7 running", seq_state, 1);
        chk("R7 d valid", d_req_valid, 1);
        chk("R7 d fields", {d_req_we, d_req_addr, d_req_size}, {we, a, sz});
        chk("R7 no adv", pc_adv, 0);
        chk("R9 rd count", unc_rd_cnt, exp_rd);
        chk("R9 wr count", unc_wr_cnt, exp_wr);
        if (refuse) begin
            d_req_accept = 0;
            tick();
            chk("R7 d retry state", seq_state, 4);
            d_retry = 1;
            tick();
            d_retry = 0;
            chk("R7 d wait", seq_state, 5);
            chk("R7 d replay", d_req_valid, 1);
            tick();
            chk("R7 d replay once", d_req_valid, 0);
        end else begin
            d_req_accept = 1;
            tick();
            d_req_accept = 0;
            chk("R7 d wait", seq_state, 5);
        end
        d_resp = 1; d_resp_ok = 1;
        tick();
        d_resp = 0; d_resp_ok = 0;
        pc_exp = pc_exp + 4;
        chk("R8 running", seq_state, 1);
        chk("R8 adv", pc_adv, 1);
        chk("R8 pc", pc, pc_exp);
        chk("R8 irq", irq_chk, 1);
        tick();
        chk("R8 next addr", {if_req_valid, if_req_addr}, {1'b1, pc_exp});
        if_req_accept = 1;
        tick();
        if_req_accept = 0;
        chk("R8 back to wait", seq_state, 3);
    endtask

    // R10: switch-out from Running drops the pending fetch
    task automatic test_swout_run();
        if_resp = 1; ins_is_mem = 0;
        tick();
        if_resp = 0;
        chk("R10 running", seq_state, 1);
        swout_req = 1;
        tick();
        swout_req = 0;
        chk("R10 switched", seq_state, 6);
        chk("R10 ack", swout_ack, 1);
        chk("R10 fetch dropped", if_req_valid, 0);
        tick();
        chk("R10 no fetch", {if_req_valid, irq_chk}, 0);
        act_req = 1;
        tick();
        act_req = 0;
        chk("R11 act in swout err", proto_err, 1);
        chk("R11 act in swout state", seq_state, 6);
    endtask

    // R11: illegal events, each after a fresh reset
    task automatic test_errors();
        do_reset();
        if_retry = 1;
        tick();
        if_retry = 0;
        chk("R11 retry no hold", proto_err, 1);
        chk("R11 retry state", seq_state, 0);
        do_reset();
        test_activate(0);
        if_req_accept = 1;
        tick();
        if_req_accept = 0;
        d_resp = 1; d_resp_ok = 1;
        tick();
        d_resp = 0; d_resp_ok = 0;
        chk("R11 resp outside wait", proto_err, 1);
        chk("R11 resp state", seq_state, 3);
        do_reset();
        act_req = 1; act_delay = 4'd5;
        tick();
        tick();
        act_req = 0;
        chk("R11 double act", proto_err, 1);
        chk("R11 double act state", seq_state, 1);
    endtask

    // R8: failed data response
    task automatic test_data_fail();
        do_reset();
        test_activate(0);
        if_req_accept = 1;
        tick();
        if_req_accept = 0;
        ins_is_mem = 1; ls_we = 0; ls_uncached = 0; ls_addr = 32'h40; ls_size = 2'd2;
        if_resp = 1;
        tick();
        if_resp = 0; ins_is_mem = 0;
        d_req_accept = 1;
        tick();
        d_req_accept = 0;
        chk("R8 pre err", proto_err, 0);
        d_resp = 1; d_resp_ok = 0;
        tick();
        d_resp = 0;
        chk("R8 fail err", proto_err, 1);
        chk("R8 fail state", seq_state, 5);
        chk("R8 fail no adv", pc_adv, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : main
        test_reset();
        test_activate(3);
        test_fetch_plain();
        test_fetch_refuse();
        test_swout_busy();
        test_data(1'b0, 1'b1, 32'h0000_1230, 2'd3, 1'b1);
        test_data(1'b1, 1'b1, 32'h0000_0456, 2'd1, 1'b0);
        test_data(1'b1, 1'b0, 32'h0000_0789, 2'd0, 1'b0);
        test_swout_run();
        test_errors();
        test_data_fail();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule